// File: doc/BRIEF.md
# SMBus Slave Front End with Alert Response

This block is the bus-facing half of a monitoring device on a two-wire SMBus. It samples SCL and SDA with the system clock, cleans both lines through a synchroniser and a short glitch filter, and finds START and STOP conditions and clock edges. It shifts in the address byte, acknowledges its own 7-bit address, and drives SDA only through an open-drain pull-down enable. The register file that serves ordinary reads and writes sits behind this block and is not part of it. After the address phase of its own address, the block releases SDA and leaves data handling to that layer.

The block also owns the alert line. A set of status event inputs, a monitoring-cycle tick and an interrupt-enable bit decide when the alert pull-down is engaged. The enable bit is loaded through a one-cycle software write strobe. When a host reads the Alert Response Address, the block answers with its own address while it is alerting, and then clears its enable bit, which releases the alert line. The line comes back only after software re-arms the enable and a later tick finds a status bit still high.

Two recovery paths return the interface to idle and emit a one-cycle bus reset pulse: SCL held low beyond the timeout during a transfer, and a START followed directly by a STOP. The block never drives SCL, so other devices may stretch the clock freely.

Top module: `smb_alert_slave`

## Requirements
- R1: After reset, sda_oe, alert_oe and bus_rst are 0 and the interrupt enable is 0.
- R2: An address byte whose upper seven bits equal OWN_ADDR is acknowledged (SDA pulled low during the ninth clock) for either value of the direction bit. Any other address is not acknowledged, and SDA stays released until the next START.
- R3: The address byte 8'h19 (Alert Response Address 7'b0001100 with the direction bit at 1) is acknowledged only when the enable is 1 and at least one status input is high. Otherwise the byte gets no acknowledge, SDA stays released until the next START, and 8'h18 (direction bit 0) is never acknowledged.
- R4: After acknowledging 8'h19, the block sends one byte MSB first on the following eight clocks. Bits 7:1 hold OWN_ADDR and bit 0 is 0. It then releases SDA for the master's NACK and STOP.
- R5: When the acknowledge clock of an answered 8'h19 ends, the enable clears and alert_oe falls. Further ticks with status high leave alert_oe at 0 until the enable is written back to 1.
- R6: alert_oe is a register. Its next value is 1 when the next enable value is 1, at least one status input is high, and either alert_oe is 1 or mon_tick is high. It is 0 otherwise.
- R7: When en_wr is high at a clock edge, the enable takes en_wdata at that edge. That value already counts as the next enable value for alert_oe in the same cycle.
- R8: While a transfer is in progress, filtered SCL staying low for CLK_MHZ*TOUT_US cycles aborts it. SDA is released, bus_rst pulses for one cycle, and a new START is accepted. Shorter clock-low stretches leave the transfer intact. The default of 30000 us lies between the 25 ms and 35 ms bounds.
- R9: A START followed by a STOP with no data bit between them pulses bus_rst for one cycle. A STOP after a complete byte gives no pulse.
- R10: A level on SCL or SDA that lasts fewer than three clocks after synchronisation is ignored. A low pulse of two cycles on SDA while SCL is high creates no START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level from the pad |
| sda_i | input | 1 | SDA line level from the pad |
| sda_oe | output | 1 | 1 pulls SDA low |
| alert_oe | output | 1 | 1 pulls the alert line low |
| bus_rst | output | 1 | One-cycle pulse on timeout abort or START-STOP |
| stat_evt | input | NSTAT | Status event bits, any high requests an alert |
| mon_tick | input | 1 | Monitoring-cycle tick, one cycle wide |
| en_wr | input | 1 | Software write strobe for the interrupt enable |
| en_wdata | input | 1 | Value written to the interrupt enable |

## Verification
The hardest situation to reach from the ports is a timeout that strikes while the slave itself holds SDA low in an acknowledge clock. The bench gets there by sending a matching address, parking SCL low right after the eighth bit, and probing sda_oe once before the limit and once after it. The re-arm sequence after an answered Alert Response read is also subtle. The bench completes that read, pulses ticks with status still high, then writes the enable and ticks again. Meanwhile a behavioural model checks alert_oe on every clock.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ACK, ST_TX, ST_WAIT
  } smb_st_t;
  localparam logic [7:0] ARA_RD = 8'h19;
endpackage

// File: rtl/smb_line_filt.sv
module smb_line_filt #(
  parameter int SYNC  = 2,
  parameter int NSAMP = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [SYNC-1:0]  sync_q;
  logic [NSAMP-1:0] hist_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      hist_q <= '1;
      dout   <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], din};
      hist_q <= {hist_q[NSAMP-2:0], sync_q[SYNC-1]};
      if (&hist_q)
        dout <= 1'b1;
      else if (~|hist_q)
        dout <= 1'b0;
    end
  end
endmodule

// File: rtl/smb_clk_tout.sv
module smb_clk_tout #(
  parameter int LIMIT = 1000,
  parameter int TW    = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  output logic [TW-1:0] cnt,
  output logic          hit
);
  assign hit = run && (cnt == TW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || !run || hit)
      cnt <= '0;
    else
      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/smb_alert_ctl.sv
module smb_alert_ctl (
  input  logic clk,
  input  logic rst,
  input  logic stat_any,
  input  logic mon_tick,
  input  logic en_wr,
  input  logic en_wdata,
  input  logic ara_clr,
  output logic int_en,
  output logic alert_oe
);
  logic en_nxt;

  always_comb begin
    if (en_wr)
      en_nxt = en_wdata;
    else if (ara_clr)
      en_nxt = 1'b0;
    else
      en_nxt = int_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      int_en   <= 1'b0;
      alert_oe <= 1'b0;
    end else begin
      int_en   <= en_nxt;
      alert_oe <= en_nxt && stat_any && (alert_oe || mon_tick);
    end
  end
endmodule

// File: rtl/smb_alert_slave.sv
module smb_alert_slave
  import smb_pkg::*;
#(
  parameter logic [6:0] OWN_ADDR = 7'h2E,
  parameter int         NSTAT    = 4,
  parameter int         CLK_MHZ  = 125,
  parameter int         TOUT_US  = 30000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  output logic             alert_oe,
  output logic             bus_rst,
  input  logic [NSTAT-1:0] stat_evt,
  input  logic             mon_tick,
  input  logic             en_wr,
  input  logic             en_wdata
);
  localparam int TOUT_CYC = CLK_MHZ * TOUT_US;
  localparam int TW       = $clog2(TOUT_CYC + 1);
  localparam logic [7:0] RESP = {OWN_ADDR, 1'b0};

  logic [1:0] raw_w, filt_w;
  logic       scl_f, sda_f, scl_p, sda_p;
  logic       scl_rise, scl_fall, start_c, stop_c;
  logic       stat_any, int_en, ara_clr, alert_ok;
  logic       tout_run, tout_hit;
  logic [TW-1:0] tout_cnt;
  smb_st_t    st;
  logic [2:0] bitcnt;
  logic [7:0] sreg, txsh, abyte;
  logic       smp, got_rise, ara_act;

  assign raw_w = {sda_i, scl_i};

  generate
    for (genvar g = 0; g < 2; g++) begin : g_line
      smb_line_filt #(.SYNC(2), .NSAMP(3)) u_filt (
        .clk(clk), .rst(rst), .din(raw_w[g]), .dout(filt_w[g])
      );
    end
  endgenerate

  assign scl_f = filt_w[0];
  assign sda_f = filt_w[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  assign scl_rise = scl_f && !scl_p;
  assign scl_fall = !scl_f && scl_p;
  assign start_c  = scl_f && scl_p && sda_p && !sda_f;
  assign stop_c   = scl_f && scl_p && !sda_p && sda_f;

  assign stat_any = |stat_evt;
  assign alert_ok = int_en && stat_any;
  assign tout_run = (st != ST_IDLE) && !scl_f;
  assign abyte    = {sreg[6:0], smp};

  smb_clk_tout #(.LIMIT(TOUT_CYC), .TW(TW)) u_tout (
    .clk(clk), .rst(rst), .run(tout_run), .cnt(tout_cnt), .hit(tout_hit)
  );

  smb_alert_ctl u_alert (
    .clk(clk), .rst(rst), .stat_any(stat_any), .mon_tick(mon_tick),
    .en_wr(en_wr), .en_wdata(en_wdata), .ara_clr(ara_clr),
    .int_en(int_en), .alert_oe(alert_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      bitcnt   <= '0;
      sreg     <= '0;
      txsh     <= '0;
      smp      <= 1'b0;
      got_rise <= 1'b0;
      sda_oe   <= 1'b0;
      bus_rst  <= 1'b0;
      ara_act  <= 1'b0;
      ara_clr  <= 1'b0;
    end else begin
      bus_rst <= 1'b0;
      ara_clr <= 1'b0;
      if (tout_hit) begin
        st      <= ST_IDLE;
        sda_oe  <= 1'b0;
        bus_rst <= 1'b1;
      end else if (start_c) begin
        st       <= ST_ADDR;
        bitcnt   <= '0;
        got_rise <= 1'b0;
        sda_oe   <= 1'b0;
        ara_act  <= 1'b0;
      end else if (stop_c) begin
        if (st == ST_ADDR && bitcnt == 3'd0)
          bus_rst <= 1'b1;
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        if (scl_rise) begin
          smp      <= sda_f;
          got_rise <= 1'b1;
        end
        if (scl_fall && got_rise) begin
          got_rise <= 1'b0;
          case (st)
            ST_ADDR: begin
              sreg <= abyte;
              if (bitcnt == 3'd7) begin
                bitcnt <= '0;
                if (abyte[7:1] == OWN_ADDR || (abyte == ARA_RD && alert_ok)) begin
                  st      <= ST_ACK;
                  sda_oe  <= 1'b1;
                  ara_act <= (abyte == ARA_RD);
                end else begin
                  st     <= ST_WAIT;
                  sda_oe <= 1'b0;
                end
              end else begin
                bitcnt <= bitcnt + 3'd1;
              end
            end
            ST_ACK: begin
              if (ara_act) begin
                st      <= ST_TX;
                sda_oe  <= !RESP[7];
                txsh    <= {RESP[6:0], 1'b0};
                bitcnt  <= '0;
                ara_clr <= 1'b1;
              end else begin
                st     <= ST_WAIT;
                sda_oe <= 1'b0;
              end
            end
            ST_TX: begin
              if (bitcnt == 3'd7) begin
                st     <= ST_WAIT;
                sda_oe <= 1'b0;
              end else begin
                sda_oe <= !txsh[7];
                txsh   <= {txsh[6:0], 1'b0};
                bitcnt <= bitcnt + 3'd1;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/smb_alert_chk.sv
module smb_alert_chk (
  input logic clk,
  input logic rst,
  input logic alert_oe,
  input logic int_en,
  input logic mon_tick,
  input logic stat_any,
  input logic en_wr,
  input logic ara_clr,
  input logic bus_rst,
  input logic sda_oe,
  input logic tout_hit
);
  // R6: alert can only come up one cycle after a tick with status present
  a_r6_rise_after_tick: assert property (@(posedge clk) disable iff (rst)
    $rose(alert_oe) |-> ($past(mon_tick) && $past(stat_any)));

  // R6: no status means alert released on the next cycle
  a_r6_drop_when_quiet: assert property (@(posedge clk) disable iff (rst)
    !stat_any |=> !alert_oe);

  // R5 / R7: enable only falls after a software write or an answered alert read
  a_r5_en_fall_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(int_en) |-> ($past(en_wr) || $past(ara_clr)));

  // R8: a timeout hit aborts with a pulse and a released SDA
  a_r8_abort_on_hit: assert property (@(posedge clk) disable iff (rst)
    tout_hit |=> (bus_rst && !sda_oe));

  // R9: bus reset is a single-cycle pulse and never coexists with SDA drive
  a_r9_rst_single: assert property (@(posedge clk) disable iff (rst)
    bus_rst |=> !bus_rst);

  a_r9_rst_releases: assert property (@(posedge clk) disable iff (rst)
    bus_rst |-> !sda_oe);
endmodule

bind smb_alert_slave smb_alert_chk u_chk (
  .clk(clk), .rst(rst), .alert_oe(alert_oe), .int_en(int_en),
  .mon_tick(mon_tick), .stat_any(stat_any), .en_wr(en_wr),
  .ara_clr(ara_clr), .bus_rst(bus_rst), .sda_oe(sda_oe), .tout_hit(tout_hit)
);

// File: tb/smb_alert_slave_tb.sv
module smb_alert_slave_tb;
  localparam logic [6:0] OWN = 7'h2E;
  localparam int NS = 4;
  localparam int Q  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, alert_oe, bus_rst;
  logic [NS-1:0] stat = '0;
  logic tick = 1'b0, en_wr = 1'b0, en_wd = 1'b0;
  logic sda_ln;

  int compared = 0, mismatched = 0, nrst = 0;
  logic skip = 1'b0, done = 1'b0;
  logic men = 1'b0, malert = 1'b0;

  always #4 clk = ~clk;
  assign sda_ln = sda_m & ~sda_oe;

  smb_alert_slave #(.OWN_ADDR(OWN), .NSTAT(NS), .CLK_MHZ(125), .TOUT_US(8)) u_dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_ln), .sda_oe(sda_oe),
    .alert_oe(alert_oe), .bus_rst(bus_rst), .stat_evt(stat), .mon_tick(tick),
    .en_wr(en_wr), .en_wdata(en_wd)
  );

  // behavioural reference for the alert line (R6, R7)
  always @(posedge clk) begin
    if (bus_rst) nrst <= nrst + 1;
    if (rst || skip) begin
      men    <= 1'b0;
      malert <= 1'b0;
    end else begin
      logic en_n;
      en_n = en_wr ? en_wd : men;
      men    <= en_n;
      malert <= en_n && (|stat) && (malert || tick);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (!rst && !skip && !done) chk("R6 alert per-clock model", alert_oe, malert);

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask
  task automatic bus_start(); sda_m = 1; wt(Q); scl_m = 1; wt(Q); sda_m = 0; wt(Q); scl_m = 0; wt(Q); endtask
  task automatic bus_stop(); sda_m = 0; wt(Q); scl_m = 1; wt(Q); sda_m = 1; wt(Q); endtask
  task automatic bit_io(input logic b, input int stretch, output logic r);
    sda_m = b; wt(Q + stretch); scl_m = 1; wt(Q); r = sda_ln; wt(Q); scl_m = 0; wt(Q);
  endtask
  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_io(v[i], 0, r);
    bit_io(1'b1, 0, ack);
  endtask
  task automatic recv_byte(output logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) begin bit_io(1'b1, 0, r); v[i] = r; end
  endtask
  task automatic sw_en(input logic v); en_wr = 1; en_wd = v; wt(1); en_wr = 0; endtask
  task automatic pulse_tick(); tick = 1; wt(1); tick = 0; endtask

  initial begin
    logic ack, r;
    logic [7:0] b;
    int n0;
    wt(10); rst = 0; wt(2);
    chk("R1 sda_oe after reset", sda_oe, 0);
    chk("R1 alert_oe after reset", alert_oe, 0);
    chk("R1 bus_rst after reset", bus_rst, 0);
    stat = 4'b0010; pulse_tick(); wt(1);
    chk("R1 enable 0 so tick gives no alert", alert_oe, 0);

    n0 = nrst;
    bus_start(); send_byte({OWN, 1'b0}, ack); chk("R2 own write ack", ack, 0); bus_stop();
    bus_start(); send_byte({OWN, 1'b1}, ack); chk("R2 own read ack", ack, 0); bus_stop();
    wt(10); chk("R9 normal stop no pulse", nrst, n0);

    bus_start(); send_byte(8'h50, ack); chk("R2 foreign addr nack", ack, 1);
    recv_byte(b); chk("R2 released after nack", b, 8'hFF); bus_stop();

    bus_start(); send_byte(8'h19, ack); chk("R3 ara nack with enable 0", ack, 1);
    recv_byte(b); chk("R3 released after ara nack", b, 8'hFF); bus_stop();

    stat = '0; sw_en(1); pulse_tick(); wt(1);
    chk("R6 no status no alert", alert_oe, 0);
    bus_start(); send_byte(8'h19, ack); chk("R3 ara nack with no status", ack, 1); bus_stop();

    stat = 4'b1000; wt(3); chk("R6 no tick yet", alert_oe, 0);
    pulse_tick(); chk("R6 alert after tick", alert_oe, 1);
    bus_start(); send_byte(8'h18, ack); chk("R3 ara write bit nack", ack, 1); bus_stop();
    chk("R6 alert held", alert_oe, 1);

    skip = 1;
    bus_start(); send_byte(8'h19, ack); chk("R3 ara ack when alerting", ack, 0);
    recv_byte(b); chk("R4 ara response byte", b, {OWN, 1'b0});
    bit_io(1'b1, 0, r); bus_stop();
    chk("R5 alert released after ara", alert_oe, 0);
    wt(2); skip = 0;
    pulse_tick(); wt(2); pulse_tick(); wt(1);
    chk("R5 no re-assert without enable", alert_oe, 0);
    sw_en(1); wt(2); chk("R7 write alone no alert", alert_oe, 0);
    pulse_tick(); chk("R5 re-assert after rearm", alert_oe, 1);
    stat = '0; wt(1); chk("R6 drop with no status", alert_oe, 0);

    n0 = nrst; bus_start(); bus_stop(); wt(20);
    chk("R9 start-stop pulse", nrst, n0 + 1);

    n0 = nrst; sda_m = 0; wt(2); sda_m = 1; wt(20);
    chk("R10 short sda glitch ignored", nrst, n0);
    n0 = nrst; sda_m = 0; wt(5); sda_m = 1; wt(20);
    chk("R10 longer low seen as start-stop", nrst, n0 + 1);

    n0 = nrst;
    bus_start();
    for (int i = 7; i >= 0; i--) bit_io(OWN[(i > 0) ? i - 1 : 0] & (i > 0), 0, r);
    bit_io(1'b1, 500, ack);
    chk("R8 stretch tolerated ack", ack, 0); bus_stop();
    chk("R8 stretch no abort", nrst, n0);

    n0 = nrst;
    bus_start();
    for (int i = 7; i >= 1; i--) bit_io(OWN[i - 1], 0, r);
    bit_io(1'b0, 0, r);
    sda_m = 1; wt(880);
    chk("R8 still acking before limit", sda_oe, 1);
    wt(400);
    chk("R8 released after timeout", sda_oe, 0);
    chk("R8 abort pulse", nrst, n0 + 1);
    scl_m = 1; wt(Q);
    bus_start(); send_byte({OWN, 1'b0}, ack); chk("R8 new start after abort", ack, 0); bus_stop();

    wt(10);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      compared++; mismatched++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule